// File: doc/BRIEF.md
# I2C Master Byte Shifter with Arbitration Check

This block moves one byte across an I2C bus while a separate timing unit generates SCL and the START/STOP conditions. The timing unit sends one-cycle strobes to mark each SCL rising edge and each SCL falling edge. The block uses them to put transmit bits on SDA, most significant bit first, or to collect received bits. It then handles the acknowledge bit and reports the result. SDA is open drain: the block only asks for the line to be pulled low, and it reads back the level actually present on the bus.

In transmit mode every bit the block releases, which is a 1, is compared with the bus level at the SCL rising edge. A 0 on the bus means another master has won arbitration. The block then stops driving for the rest of the byte but keeps shifting in what the bus carries. In every mode the data output ends holding the byte that was really on the bus. The outcome depends on the phase latched at start:
- Losing during an address byte hands the controller over to slave-address listening.
- Losing during a data byte sends it back to idle.
- A NACK also sends it back to idle.

The state machine has three states: `ST_IDLE`, `ST_BITS` and `ST_ACK`. Its transitions are:
- IDLE→BITS on an accepted start.
- BITS→BITS on each falling strobe before the last bit.
- BITS→ACK on the last falling strobe when arbitration was not lost.
- BITS→IDLE on the last falling strobe after a loss.
- ACK→IDLE on the acknowledge bit's falling strobe.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sda_pull_o` and all status outputs are 0.
- R2: `start_i` is accepted only when `busy_o` is 0. It latches `tx_byte_i`, `rx_mode_i`, `addr_phase_i` and `ack_send_i`. While a byte is in progress, `start_i` and changes on those inputs have no effect on the bus or on the result.
- R3: In transmit mode bit 7 is presented first and bit 0 last. `sda_pull_o`=1 means a 0 bit. The next bit appears only after an `scl_fall_i` strobe, and `sda_pull_o` never changes on an `scl_rise_i` strobe.
- R4: SDA is sampled on each `scl_rise_i` strobe. The first sample lands in bit 7, and at `done_o` `data_o` holds the eight sampled bus levels, in both modes.
- R5: In transmit mode, a released bit (1) sampled as 0 is an arbitration loss. From then on `sda_pull_o` stays 0 for the rest of the byte, bits keep being sampled, and there is no acknowledge bit.
- R6: In transmit mode, without a loss, SDA is released during the acknowledge bit and sampled at its rising strobe. A high level sets `nack_o` and `to_idle_o`.
- R7: In receive mode, during the acknowledge bit `sda_pull_o` equals the `ack_send_i` value latched at start. Data bits are never driven.
- R8: A loss during an address byte sets `arb_lost_o`, `lost_addr_o` and `to_slave_o`. A loss during a data byte sets `arb_lost_o` and `to_idle_o`. `to_idle_o` and `to_slave_o` are never both 1.
- R9: `done_o` is a one-cycle pulse in the cycle after the final `scl_fall_i` strobe: the acknowledge bit's, or bit 0's after a loss. The status outputs hold until the next accepted start.
- R10: An accepted start clears all status outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one byte transfer (taken only when idle) |
| rx_mode_i | input | 1 | 1 = receive a byte, 0 = transmit |
| addr_phase_i | input | 1 | 1 = this byte is an address byte |
| tx_byte_i | input | BYTE_W | Byte to transmit |
| ack_send_i | input | 1 | Receive mode: 1 = acknowledge the byte |
| scl_rise_i | input | 1 | One-cycle strobe at each SCL rising edge |
| scl_fall_i | input | 1 | One-cycle strobe at each SCL falling edge |
| sda_i | input | 1 | Level present on SDA |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| data_o | output | BYTE_W | Byte sampled from the bus |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-byte pulse |
| arb_lost_o | output | 1 | Arbitration lost in the last byte |
| lost_addr_o | output | 1 | The loss happened in an address byte |
| nack_o | output | 1 | Transmitted byte was not acknowledged |
| to_idle_o | output | 1 | Controller should return to idle |
| to_slave_o | output | 1 | Controller should listen for its slave address |

## Verification
The bench models another bus device that pulls SDA low bit by bit, and it computes the bus as the wired AND of the two sides. Several patterns are run:
- A contention-free transmit separates a correct MSB-first drive order from a reversed one.
- Competitor patterns that lose at bit 6 of a data byte and at bit 4 of an address byte separate the idle outcome from the slave handover. They also confirm that `data_o` follows the bus rather than the driven byte after the loss.
- An all-zero byte against a pulling competitor shows that driven zeros never count as a loss.
- Receive bytes with and without an acknowledge, plus a transmit ending in a NACK, separate the two uses of the acknowledge slot.
- A start pulse with a different byte, issued mid-transfer, must leave both the bus and the result unchanged.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_ACK  = 2'd2
    } shf_state_t;
endpackage

// File: rtl/i2cs_bit_counter.sv
module i2cs_bit_counter #(
    parameter int BYTE_W = 8,
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(BYTE_W - 1);
        end else if (step_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/i2cs_shift_pair.sv
module i2cs_shift_pair #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              shift_out_i,
    input  logic              shift_in_i,
    input  logic              bus_bit_i,
    output logic              out_bit_o,
    output logic [BYTE_W-1:0] in_byte_o
);
    logic [BYTE_W-1:0] out_q;
    logic [BYTE_W-1:0] in_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (load_i) begin
            out_q <= load_val_i;
        end else if (shift_out_i) begin
            out_q <= {out_q[BYTE_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (shift_in_i) begin
            in_q <= {in_q[BYTE_W-2:0], bus_bit_i};
        end
    end

    assign out_bit_o = out_q[BYTE_W-1];
    assign in_byte_o = in_q;
endmodule

// File: rtl/i2cs_status_reg.sv
module i2cs_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic capture_i,
    input  logic lost_i,
    input  logic addr_i,
    input  logic nack_i,
    output logic done_o,
    output logic arb_lost_o,
    output logic lost_addr_o,
    output logic nack_o,
    output logic to_idle_o,
    output logic to_slave_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            arb_lost_o  <= 1'b0;
            lost_addr_o <= 1'b0;
            nack_o      <= 1'b0;
            to_idle_o   <= 1'b0;
            to_slave_o  <= 1'b0;
        end else begin
            done_o <= capture_i;
            if (clear_i) begin
                arb_lost_o  <= 1'b0;
                lost_addr_o <= 1'b0;
                nack_o      <= 1'b0;
                to_idle_o   <= 1'b0;
                to_slave_o  <= 1'b0;
            end else if (capture_i) begin
                arb_lost_o  <= lost_i;
                lost_addr_o <= lost_i && addr_i;
                nack_o      <= !lost_i && nack_i;
                to_idle_o   <= (lost_i && !addr_i) || (!lost_i && nack_i);
                to_slave_o  <= lost_i && addr_i;
            end
        end
    end

    // R8: the two outcomes exclude each other
    a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(to_idle_o && to_slave_o));
    // R6: a NACK always means return to idle and never coexists with a loss
    a_r6_nack_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |-> (to_idle_o && !arb_lost_o));
    // R8: address-phase loss implies a loss
    a_r8_addr_implies_lost: assert property (@(posedge clk) disable iff (!rst_n)
        lost_addr_o |-> arb_lost_o);
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rx_mode_i,
    input  logic              addr_phase_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              ack_send_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              arb_lost_o,
    output logic              lost_addr_o,
    output logic              nack_o,
    output logic              to_idle_o,
    output logic              to_slave_o
);
    shf_state_t state_q, state_d;

    logic rx_q, addr_q, ack_q, lost_q, nack_q;
    logic load, rise, fall, last_bit, out_bit, lose_now, finish;

    // strobe qualification: a rise strobe takes priority over a fall strobe
    assign load = (state_q == ST_IDLE) && start_i;
    assign rise = scl_rise_i;
    assign fall = scl_fall_i && !scl_rise_i;

    assign lose_now = (state_q == ST_BITS) && rise && !rx_q && !lost_q
                      && out_bit && !sda_i;
    assign finish   = ((state_q == ST_BITS) && fall && last_bit && lost_q)
                   || ((state_q == ST_ACK) && fall);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_BITS;
            ST_BITS: if (fall && last_bit) state_d = lost_q ? ST_IDLE : ST_ACK;
            ST_ACK:  if (fall) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // transfer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= 1'b0;
            addr_q <= 1'b0;
            ack_q  <= 1'b0;
            lost_q <= 1'b0;
            nack_q <= 1'b0;
        end else if (load) begin
            rx_q   <= rx_mode_i;
            addr_q <= addr_phase_i;
            ack_q  <= ack_send_i;
            lost_q <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            if (lose_now) lost_q <= 1'b1;
            if ((state_q == ST_ACK) && rise) nack_q <= !rx_q && sda_i;
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_BITS: sda_pull_o = !rx_q && !lost_q && !out_bit;
            ST_ACK:  sda_pull_o = rx_q && ack_q;
            default: busy_o = 1'b0;
        endcase
    end

    i2cs_bit_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i ((state_q == ST_BITS) && fall),
        .last_o (last_bit)
    );

    i2cs_shift_pair #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_val_i  (tx_byte_i),
        .shift_out_i ((state_q == ST_BITS) && fall),
        .shift_in_i  ((state_q == ST_BITS) && rise),
        .bus_bit_i   (sda_i),
        .out_bit_o   (out_bit),
        .in_byte_o   (data_o)
    );

    i2cs_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (load),
        .capture_i   (finish),
        .lost_i      (lost_q),
        .addr_i      (addr_q),
        .nack_i      (nack_q),
        .done_o      (done_o),
        .arb_lost_o  (arb_lost_o),
        .lost_addr_o (lost_addr_o),
        .nack_o      (nack_o),
        .to_idle_o   (to_idle_o),
        .to_slave_o  (to_slave_o)
    );

    // R3: SDA drive never moves on a rising strobe while a byte is active
    a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise_i && state_q != ST_IDLE) |=> $stable(sda_pull_o));
    // R5: once arbitration is lost the data bits are released
    a_r5_release_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q && state_q == ST_BITS) |-> !sda_pull_o);
    // R9: the end pulse follows a fall strobe and leaves the block idle
    a_r9_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(scl_fall_i) && !busy_o));
    // R10: an accepted start clears the status in the next cycle
    a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> !(arb_lost_o || nack_o || to_idle_o || to_slave_o));
    // R7: receive mode never drives a data bit
    a_r7_rx_no_data_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q && state_q == ST_BITS) |-> !sda_pull_o);
endmodule

// File: tb/i2c_byte_shifter_bench.sv
module i2c_byte_shifter_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] data;
        logic       lost;
        logic       laddr;
        logic       nack;
        logic       idle;
        logic       slave;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, rx_mode_i = 1'b0, addr_phase_i = 1'b0, ack_send_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic scl_rise_i = 1'b0, scl_fall_i = 1'b0;
    logic other_pull = 1'b0;
    logic sda_pull_o, busy_o, done_o, arb_lost_o, lost_addr_o, nack_o, to_idle_o, to_slave_o;
    logic [7:0] data_o;
    logic sda_bus;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    exp_t exp_q[$];

    assign sda_bus = !(sda_pull_o || other_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_shifter u_i2c_byte_shifter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_mode_i(rx_mode_i),
        .addr_phase_i(addr_phase_i), .tx_byte_i(tx_byte_i), .ack_send_i(ack_send_i),
        .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i), .sda_i(sda_bus),
        .sda_pull_o(sda_pull_o), .data_o(data_o), .busy_o(busy_o), .done_o(done_o),
        .arb_lost_o(arb_lost_o), .lost_addr_o(lost_addr_o), .nack_o(nack_o),
        .to_idle_o(to_idle_o), .to_slave_o(to_slave_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the expected result at each end pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R4 data_o", {24'h0, data_o}, {24'h0, e.data});
                chk("R5 arb_lost_o", {31'h0, arb_lost_o}, {31'h0, e.lost});
                chk("R8 lost_addr_o", {31'h0, lost_addr_o}, {31'h0, e.laddr});
                chk("R6 nack_o", {31'h0, nack_o}, {31'h0, e.nack});
                chk("R8 to_idle_o", {31'h0, to_idle_o}, {31'h0, e.idle});
                chk("R8 to_slave_o", {31'h0, to_slave_o}, {31'h0, e.slave});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_rise();
        scl_rise_i = 1'b1; tick(1); scl_rise_i = 1'b0; tick(2);
    endtask

    task automatic strobe_fall();
        scl_fall_i = 1'b1; tick(1); scl_fall_i = 1'b0;
    endtask

    // driver: computes and queues the expected result, then runs the bus
    task automatic run_byte(input logic [7:0] tx, input logic rx, input logic addr,
                            input logic ack_send, input logic [7:0] other,
                            input logic other_ack_low, input logic poke);
        exp_t e;
        logic lost = 1'b0;
        logic [7:0] pulls;
        for (int i = 7; i >= 0; i--) begin
            logic drive;
            logic bus;
            drive    = rx ? 1'b1 : (lost ? 1'b1 : tx[i]);
            pulls[i] = !rx && !lost && !tx[i];
            bus      = drive && other[i];
            e.data[i] = bus;
            if (!rx && !lost && tx[i] && !bus) lost = 1'b1;
        end
        e.lost  = lost;
        e.laddr = lost && addr;
        e.nack  = !lost && !rx && !other_ack_low;
        e.idle  = (lost && !addr) || e.nack;
        e.slave = lost && addr;
        exp_q.push_back(e);

        tick(1);
        tx_byte_i = tx; rx_mode_i = rx; addr_phase_i = addr; ack_send_i = ack_send;
        start_i = 1'b1; tick(1); start_i = 1'b0;
        chk("R2 busy after start", {31'h0, busy_o}, 1);
        chk("R10 status cleared", {28'h0, arb_lost_o, nack_o, to_idle_o, to_slave_o}, 0);
        for (int i = 7; i >= 0; i--) begin
            other_pull = !other[i];
            tick(2);
            if (poke && i == 4) begin
                tx_byte_i = ~tx; rx_mode_i = !rx; addr_phase_i = !addr;
                start_i = 1'b1; tick(1); start_i = 1'b0;
            end
            chk(rx ? "R7 no data drive" : "R3 bit drive", {31'h0, sda_pull_o}, {31'h0, pulls[i]});
            strobe_rise();
            chk("R3 drive held after rise", {31'h0, sda_pull_o}, {31'h0, pulls[i]});
            strobe_fall();
        end
        if (!lost) begin
            other_pull = rx ? 1'b0 : other_ack_low;
            tick(2);
            chk(rx ? "R7 ack drive" : "R6 ack released", {31'h0, sda_pull_o},
                {31'h0, rx && ack_send});
            strobe_rise();
            strobe_fall();
        end
        other_pull = 1'b0;
        // the end pulse is now visible; one cycle later it must be gone
        chk("R9 done pulse", {31'h0, done_o}, 1);
        tick(1);
        chk("R9 done one cycle", {31'h0, done_o}, 0);
        chk("R9 status held", {27'h0, arb_lost_o, lost_addr_o, nack_o, to_idle_o, to_slave_o},
            {27'h0, e.lost, e.laddr, e.nack, e.idle, e.slave});
        chk("R2 idle after byte", {31'h0, busy_o}, 0);
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 reset outputs",
            {24'h0, busy_o, done_o, sda_pull_o, arb_lost_o, lost_addr_o, nack_o, to_idle_o, to_slave_o}, 0);
        run_byte(8'hA4, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0); // R3 clean address, acked
        run_byte(8'h5A, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0); // R6 NACK
        run_byte(8'hC3, 1'b0, 1'b0, 1'b0, 8'h83, 1'b1, 1'b0); // R5 R8 data loss at bit 6
        run_byte(8'hF0, 1'b0, 1'b1, 1'b0, 8'hE5, 1'b1, 1'b0); // R8 address loss at bit 4
        run_byte(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0); // R5 zeros never lose
        run_byte(8'h00, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0); // R7 receive with ack
        run_byte(8'hFF, 1'b1, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0); // R7 receive without ack
        run_byte(8'h69, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b1); // R2 start ignored mid-byte
        chk("R9 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule